// File: doc/BRIEF.md
# Trap Delegation and Interrupt Router

This block is the decision point between a hart's interrupt and exception sources and its trap entry logic. On every cycle it looks at the current privilege level, the global interrupt enable bits of the machine and supervisor levels, the pending, enable and delegation vectors for interrupts, and the delegation vector for synchronous exceptions. From these it works out whether an interrupt must be taken now, which source wins, and at which privilege level it lands. Independently, it names the privilege level that would handle the exception cause presented on its cause input.

Routing is a two-stage cascade. Sources that are pending, enabled and not delegated compete for the machine level first. Sources that are delegated are passed on to the supervisor stage, which has its own global enable. A trap never lands below the level the hart is running at. When either the user or the supervisor level is not implemented, delegation is bypassed and all enabled pending sources go straight to machine level. The whole block is combinational; the trap controller samples its outputs in the same cycle it applies the inputs.

Internally the decision is one of four named routes, chosen by a single priority chain: `ROUTE_NONE` (nothing taken), `ROUTE_FLAT` (delegation bypassed, machine target), `ROUTE_MACH` (undelegated source, machine target) and `ROUTE_SUPV` (delegated source, supervisor target). Moving from one route to another happens only through input changes: `ROUTE_FLAT` is chosen whenever a level is missing and the machine gate is open; otherwise `ROUTE_MACH` wins over `ROUTE_SUPV`, and `ROUTE_NONE` is the fall-through.

Top module: `trap_router`

## Requirements
- R1: Privilege is encoded on 2 bits as user 2'b00, supervisor 2'b01, machine 2'b11, and compared unsigned; an exception whose delegation bit (bit number equal to the cause value) is clear, or any exception when the supervisor level is absent, is routed to machine (`exc_target` = 2'b11).
- R2: An exception whose delegation bit is set while the supervisor level exists is routed to supervisor (`exc_target` = 2'b01) when the current privilege is user or supervisor.
- R3: Any computed target below the current privilege is replaced by the current privilege, for both `exc_target` and `irq_target`.
- R4: The machine level accepts interrupts whenever the current privilege is below machine; at machine privilege it accepts them only when `m_ie` is 1.
- R5: The supervisor level accepts delegated interrupts only when the supervisor level exists and the current privilege is user, or it is supervisor with `s_ie` = 1; at machine privilege delegated interrupts are never taken.
- R6: A source that is pending and enabled with its delegation bit clear is taken at machine level when the machine level accepts interrupts, ahead of any delegated source.
- R7: When no undelegated source can be taken, a pending, enabled, delegated source is taken at supervisor level when the supervisor level accepts interrupts.
- R8: When the user level or the supervisor level is absent, the delegation vector is ignored: the pending vector ANDed with the enable vector is used directly, the target is machine, and the take depends only on `m_ie` (the current privilege is then machine).
- R9: Among competing candidates the winner follows one fixed order by bit number: 11 (machine external), 3 (machine software), 7 (machine timer), 9 (supervisor external), 1 (supervisor software), 5 (supervisor timer); all other pending bits are never taken.
- R10: When no interrupt is taken, `irq_take` is 0 and both `irq_index` and `irq_target` are 0.
- R11: All outputs follow the inputs combinationally, with no clock or storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_priv | input | 2 | Current privilege level (00 user, 01 supervisor, 11 machine) |
| has_umode | input | 1 | User level implemented |
| has_smode | input | 1 | Supervisor level implemented |
| m_ie | input | 1 | Machine global interrupt enable bit |
| s_ie | input | 1 | Supervisor global interrupt enable bit |
| irq_pend | input | IRQ_W (16) | Pending interrupt vector |
| irq_en | input | IRQ_W (16) | Interrupt enable vector |
| irq_deleg | input | IRQ_W (16) | Interrupt delegation vector (1 = pass to supervisor) |
| exc_deleg | input | EXC_W (16) | Exception delegation vector, indexed by cause |
| exc_cause | input | log2(EXC_W) (4) | Synchronous exception cause number |
| irq_take | output | 1 | An interrupt must be taken now |
| irq_index | output | log2(IRQ_W) (4) | Bit number of the winning interrupt |
| irq_target | output | 2 | Privilege level that takes the interrupt |
| exc_target | output | 2 | Privilege level that handles the exception cause |

## Verification
The interrupt route and the exception route are evaluated in the same cycle from one shared privilege input, so a single input vector can make the cascade send an interrupt to supervisor while the exception of that cycle is clamped or pinned to machine. The bench provokes this by presenting every stimulus with both an interrupt vector set and an exception cause, including cases where the exception bit is delegated while interrupts stay undelegated and the reverse, and under random privilege and enable mixes. Both outputs are judged on every clock against a behavioural model of the two routes written from the requirements.

// File: rtl/trap_router_pkg.sv
package trap_router_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_M = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        ROUTE_NONE,
        ROUTE_FLAT,
        ROUTE_MACH,
        ROUTE_SUPV
    } route_e;

    // Interrupt sources in falling priority, by bit number in the vectors.
    localparam int NUM_SRC = 6;
    localparam int SRC_BIT [NUM_SRC] = '{11, 3, 7, 9, 1, 5};

    // Never let a trap land below the level currently running.
    function automatic logic [1:0] floor_priv(input logic [1:0] tgt, input logic [1:0] cur);
        return (tgt < cur) ? cur : tgt;
    endfunction

endpackage

// File: rtl/trap_global_en.sv
module trap_global_en
    import trap_router_pkg::*;
(
    input  logic [1:0] cur_priv,
    input  logic       has_smode,
    input  logic       m_ie,
    input  logic       s_ie,
    output logic       m_open,
    output logic       s_open
);

    always_comb begin
        m_open = (cur_priv != PRIV_M) || m_ie;
        s_open = has_smode &&
                 ((cur_priv == PRIV_U) || ((cur_priv == PRIV_S) && s_ie));
    end

endmodule

// File: rtl/trap_irq_pick.sv
module trap_irq_pick
    import trap_router_pkg::*;
#(
    parameter int IRQ_W = 16,
    parameter int IDX_W = 4
) (
    input  logic [IRQ_W-1:0] cand,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    logic [IRQ_W-1:0] src_mask;
    logic [NUM_SRC-1:0] hit;
    logic unused_rest;

    genvar k;
    generate
        for (k = 0; k < NUM_SRC; k++) begin : g_hit
            assign hit[k] = cand[SRC_BIT[k]];
        end
    endgenerate

    always_comb begin
        src_mask = '0;
        for (int m = 0; m < NUM_SRC; m++) src_mask[SRC_BIT[m]] = 1'b1;
    end

    assign unused_rest = ^(cand & ~src_mask);

    // Walk from lowest to highest priority so the first entry wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int n = NUM_SRC - 1; n >= 0; n--) begin
            if (hit[n]) begin
                found = 1'b1;
                idx   = IDX_W'(SRC_BIT[n]);
            end
        end
    end

endmodule

// File: rtl/trap_exc_route.sv
module trap_exc_route
    import trap_router_pkg::*;
#(
    parameter int EXC_W   = 16,
    parameter int CAUSE_W = 4
) (
    input  logic [1:0]         cur_priv,
    input  logic               has_smode,
    input  logic [EXC_W-1:0]   exc_deleg,
    input  logic [CAUSE_W-1:0] exc_cause,
    output logic [1:0]         exc_target
);

    logic to_super;
    logic [1:0] raw_tgt;

    always_comb begin
        to_super = 1'b0;
        if (int'(exc_cause) < EXC_W) to_super = has_smode && exc_deleg[exc_cause];
        raw_tgt    = to_super ? PRIV_S : PRIV_M;
        exc_target = floor_priv(raw_tgt, cur_priv);
    end

endmodule

// File: rtl/trap_router.sv
module trap_router
    import trap_router_pkg::*;
#(
    parameter  int IRQ_W   = 16,
    parameter  int EXC_W   = 16,
    localparam int IDX_W   = $clog2(IRQ_W),
    localparam int CAUSE_W = $clog2(EXC_W)
) (
    input  logic [1:0]         cur_priv,
    input  logic               has_umode,
    input  logic               has_smode,
    input  logic               m_ie,
    input  logic               s_ie,
    input  logic [IRQ_W-1:0]   irq_pend,
    input  logic [IRQ_W-1:0]   irq_en,
    input  logic [IRQ_W-1:0]   irq_deleg,
    input  logic [EXC_W-1:0]   exc_deleg,
    input  logic [CAUSE_W-1:0] exc_cause,
    output logic               irq_take,
    output logic [IDX_W-1:0]   irq_index,
    output logic [1:0]         irq_target,
    output logic [1:0]         exc_target
);

    logic [IRQ_W-1:0] live, undel, del;
    logic m_open, s_open, flat;
    logic found_all, found_m, found_s;
    logic [IDX_W-1:0] idx_all, idx_m, idx_s;
    route_e route;

    assign live  = irq_pend & irq_en;
    assign undel = live & ~irq_deleg;
    assign del   = live & irq_deleg;
    assign flat  = !has_umode || !has_smode;

    trap_global_en u_gate (
        .cur_priv (cur_priv),
        .has_smode(has_smode),
        .m_ie     (m_ie),
        .s_ie     (s_ie),
        .m_open   (m_open),
        .s_open   (s_open)
    );

    trap_irq_pick #(.IRQ_W(IRQ_W), .IDX_W(IDX_W)) u_pick_all (
        .cand(live), .found(found_all), .idx(idx_all)
    );
    trap_irq_pick #(.IRQ_W(IRQ_W), .IDX_W(IDX_W)) u_pick_m (
        .cand(undel), .found(found_m), .idx(idx_m)
    );
    trap_irq_pick #(.IRQ_W(IRQ_W), .IDX_W(IDX_W)) u_pick_s (
        .cand(del), .found(found_s), .idx(idx_s)
    );

    trap_exc_route #(.EXC_W(EXC_W), .CAUSE_W(CAUSE_W)) u_exc (
        .cur_priv  (cur_priv),
        .has_smode (has_smode),
        .exc_deleg (exc_deleg),
        .exc_cause (exc_cause),
        .exc_target(exc_target)
    );

    // Route selection: one priority chain.
    always_comb begin
        if (flat)                   route = (m_open && found_all) ? ROUTE_FLAT : ROUTE_NONE;
        else if (m_open && found_m) route = ROUTE_MACH;
        else if (s_open && found_s) route = ROUTE_SUPV;
        else                        route = ROUTE_NONE;
    end

    // Outputs per route.
    always_comb begin
        irq_take   = 1'b0;
        irq_index  = '0;
        irq_target = PRIV_U;
        unique case (route)
            ROUTE_NONE: ;
            ROUTE_FLAT: begin
                irq_take   = 1'b1;
                irq_index  = idx_all;
                irq_target = PRIV_M;
            end
            ROUTE_MACH: begin
                irq_take   = 1'b1;
                irq_index  = idx_m;
                irq_target = PRIV_M;
            end
            ROUTE_SUPV: begin
                irq_take   = 1'b1;
                irq_index  = idx_s;
                irq_target = floor_priv(PRIV_S, cur_priv);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/trap_router_chk.sv
module trap_router_chk
    import trap_router_pkg::*;
#(
    parameter  int IRQ_W   = 16,
    parameter  int EXC_W   = 16,
    localparam int IDX_W   = $clog2(IRQ_W),
    localparam int CAUSE_W = $clog2(EXC_W)
) (
    input logic [1:0]         cur_priv,
    input logic               has_umode,
    input logic               has_smode,
    input logic               m_ie,
    input logic [IRQ_W-1:0]   irq_pend,
    input logic [IRQ_W-1:0]   irq_en,
    input logic [IRQ_W-1:0]   irq_deleg,
    input logic               irq_take,
    input logic [IDX_W-1:0]   irq_index,
    input logic [1:0]         irq_target,
    input logic [1:0]         exc_target
);

    always_comb begin
        if (irq_take) begin
            assert_irq_floor_R3: assert (irq_target >= cur_priv)
                else $error("interrupt routed below current privilege");
            assert_src_live_R6: assert (irq_pend[irq_index] && irq_en[irq_index])
                else $error("taken interrupt is not pending and enabled");
            if (irq_target == PRIV_M && cur_priv == PRIV_M)
                assert_mgate_R4: assert (m_ie)
                    else $error("machine interrupt taken with gate closed");
            if (irq_target == PRIV_S)
                assert_sdeleg_R7: assert (has_smode && has_umode && irq_deleg[irq_index] && cur_priv != PRIV_M)
                    else $error("supervisor interrupt without delegation");
            if (!has_umode || !has_smode)
                assert_flat_R8: assert (irq_target == PRIV_M)
                    else $error("bypass mode target not machine");
        end else begin
            assert_idle_R10: assert (irq_index == '0 && irq_target == PRIV_U)
                else $error("idle outputs not zero");
        end
        assert_exc_floor_R3: assert (exc_target >= cur_priv && exc_target != 2'b10)
            else $error("exception target illegal or below current privilege");
    end

endmodule

bind trap_router trap_router_chk #(.IRQ_W(IRQ_W), .EXC_W(EXC_W)) u_chk (
    .cur_priv  (cur_priv),
    .has_umode (has_umode),
    .has_smode (has_smode),
    .m_ie      (m_ie),
    .irq_pend  (irq_pend),
    .irq_en    (irq_en),
    .irq_deleg (irq_deleg),
    .irq_take  (irq_take),
    .irq_index (irq_index),
    .irq_target(irq_target),
    .exc_target(exc_target)
);

// File: tb/trap_router_bench.sv
module trap_router_bench;

    localparam int IRQ_W = 16;
    localparam int EXC_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [1:0]  cur_priv;
    logic        has_umode, has_smode, m_ie, s_ie;
    logic [15:0] irq_pend, irq_en, irq_deleg, exc_deleg;
    logic [3:0]  exc_cause;
    logic        irq_take;
    logic [3:0]  irq_index;
    logic [1:0]  irq_target, exc_target;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    trap_router #(.IRQ_W(IRQ_W), .EXC_W(EXC_W)) u_trap_router (
        .cur_priv(cur_priv), .has_umode(has_umode), .has_smode(has_smode),
        .m_ie(m_ie), .s_ie(s_ie), .irq_pend(irq_pend), .irq_en(irq_en),
        .irq_deleg(irq_deleg), .exc_deleg(exc_deleg), .exc_cause(exc_cause),
        .irq_take(irq_take), .irq_index(irq_index), .irq_target(irq_target),
        .exc_target(exc_target)
    );

    // Behavioural model written from the requirements.
    int order [6] = '{11, 3, 7, 9, 1, 5};
    logic       e_take;
    logic [3:0] e_idx;
    logic [1:0] e_tgt, e_exc;

    function automatic int first_of(input logic [15:0] v);
        foreach (order[i]) if (v[order[i]]) return order[i];
        return -1;
    endfunction

    task automatic model();
        logic [15:0] live;
        int w;
        bit mok, sok;
        int t;
        live = irq_pend & irq_en;
        e_take = 0; e_idx = 0; e_tgt = 0;
        mok = (cur_priv != 2'b11) || m_ie;
        sok = has_smode && (cur_priv == 2'b00 || (cur_priv == 2'b01 && s_ie));
        if (!has_umode || !has_smode) begin
            w = first_of(live);
            if (m_ie && w >= 0) begin e_take = 1; e_idx = 4'(w); e_tgt = 2'b11; end
        end else begin
            w = first_of(live & ~irq_deleg);
            if (mok && w >= 0) begin
                e_take = 1; e_idx = 4'(w); e_tgt = 2'b11;
            end else begin
                w = first_of(live & irq_deleg);
                if (sok && w >= 0) begin
                    e_take = 1; e_idx = 4'(w);
                    e_tgt = (cur_priv > 2'b01) ? cur_priv : 2'b01;
                end
            end
        end
        t = (has_smode && exc_deleg[exc_cause]) ? 1 : 3;
        if (t < int'(cur_priv)) t = int'(cur_priv);
        e_exc = 2'(t);
    endtask

    task automatic compare(input string tag);
        model();
        checks++;
        if (irq_take !== e_take || irq_index !== e_idx || irq_target !== e_tgt) begin
            failures++;
            $display("FAIL %s irq: take=%0d idx=%0d tgt=%0d expected take=%0d idx=%0d tgt=%0d",
                     tag, irq_take, irq_index, irq_target, e_take, e_idx, e_tgt);
        end
        checks++;
        if (exc_target !== e_exc) begin
            failures++;
            $display("FAIL %s exc: tgt=%0d expected %0d", tag, exc_target, e_exc);
        end
    endtask

    // Apply a vector half a cycle away from the edge, judge it before the next edge.
    task automatic apply(input logic [1:0] p, input bit hu, input bit hs, input bit mi, input bit si,
                         input logic [15:0] pe, input logic [15:0] en, input logic [15:0] dl,
                         input logic [15:0] ed, input logic [3:0] ca, input string tag);
        @(negedge clk);
        cur_priv = p; has_umode = hu; has_smode = hs; m_ie = mi; s_ie = si;
        irq_pend = pe; irq_en = en; irq_deleg = dl; exc_deleg = ed; exc_cause = ca;
        #1;
        compare(tag);
    endtask

    task automatic expect_irq(input bit tk, input int ix, input int tg, input string tag);
        checks++;
        if (irq_take !== tk || int'(irq_index) != ix || int'(irq_target) != tg) begin
            failures++;
            $display("FAIL %s direct: take=%0d idx=%0d tgt=%0d expected %0d/%0d/%0d",
                     tag, irq_take, irq_index, irq_target, tk, ix, tg);
        end
    endtask

    task automatic expect_exc(input int tg, input string tag);
        checks++;
        if (int'(exc_target) != tg) begin
            failures++;
            $display("FAIL %s direct exc: tgt=%0d expected %0d", tag, exc_target, tg);
        end
    endtask

    initial begin
        cur_priv = 2'b11; has_umode = 1; has_smode = 1; m_ie = 0; s_ie = 0;
        irq_pend = 0; irq_en = 0; irq_deleg = 0; exc_deleg = 0; exc_cause = 0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // Quiet inputs: R10 idle, R1 exception to machine.
        apply(2'b11, 1, 1, 0, 0, 16'h0, 16'h0, 16'h0, 16'h0, 4'd2, "R10");
        expect_irq(0, 0, 0, "R10"); expect_exc(3, "R1");
        // R1: undelegated cause from user goes to machine.
        apply(2'b00, 1, 1, 0, 0, 16'h0, 16'h0, 16'h0, 16'hFFF7, 4'd3, "R1");
        expect_exc(3, "R1");
        // R2: delegated cause from user to supervisor, interrupt undelegated at same time.
        apply(2'b00, 1, 1, 0, 0, 16'h0080, 16'h0080, 16'h0, 16'h0100, 4'd8, "R2");
        expect_exc(1, "R2"); expect_irq(1, 7, 3, "R6");
        // R3: delegated cause from machine clamps to machine.
        apply(2'b11, 1, 1, 1, 0, 16'h0, 16'h0, 16'h0, 16'h0100, 4'd8, "R3");
        expect_exc(3, "R3");
        // R1: no supervisor level, delegation bit ignored.
        apply(2'b11, 1, 0, 0, 0, 16'h0, 16'h0, 16'h0, 16'hFFFF, 4'd5, "R1");
        expect_exc(3, "R1");
        // R4: machine gate closed at machine privilege, open below.
        apply(2'b11, 1, 1, 0, 1, 16'h0800, 16'h0800, 16'h0, 16'h0, 4'd0, "R4");
        expect_irq(0, 0, 0, "R4");
        apply(2'b01, 1, 1, 0, 0, 16'h0800, 16'h0800, 16'h0, 16'h0, 4'd0, "R4");
        expect_irq(1, 11, 3, "R4");
        // R5: delegated source, supervisor with s_ie low / high, machine never.
        apply(2'b01, 1, 1, 1, 0, 16'h0200, 16'h0200, 16'h0200, 16'h0, 4'd0, "R5");
        expect_irq(0, 0, 0, "R5");
        apply(2'b01, 1, 1, 0, 1, 16'h0200, 16'h0200, 16'h0200, 16'h0, 4'd0, "R5");
        expect_irq(1, 9, 1, "R5");
        apply(2'b11, 1, 1, 1, 1, 16'h0200, 16'h0200, 16'h0200, 16'h0, 4'd0, "R5");
        expect_irq(0, 0, 0, "R5");
        // R7: user privilege, delegated wins when nothing undelegated; s_ie ignored.
        apply(2'b00, 1, 1, 0, 0, 16'h0022, 16'h0022, 16'h0022, 16'h0, 4'd0, "R7");
        expect_irq(1, 1, 1, "R7");
        // R6: undelegated low-rank beats delegated high-rank.
        apply(2'b00, 1, 1, 0, 0, 16'h0820, 16'h0820, 16'h0800, 16'h0, 4'd0, "R6");
        expect_irq(1, 5, 3, "R6");
        // R6/R7: machine gate closed lets delegated through at... machine privilege: nothing.
        apply(2'b11, 1, 1, 0, 1, 16'h0802, 16'h0802, 16'h0002, 16'h0, 4'd0, "R6");
        expect_irq(0, 0, 0, "R6");
        // R8: no user level, delegation ignored.
        apply(2'b11, 0, 1, 1, 0, 16'h0202, 16'h0202, 16'hFFFF, 16'h0, 4'd0, "R8");
        expect_irq(1, 9, 3, "R8");
        apply(2'b11, 1, 0, 0, 1, 16'h0202, 16'h0202, 16'hFFFF, 16'h0, 4'd0, "R8");
        expect_irq(0, 0, 0, "R8");
        // R9: full order, peel winners one by one.
        apply(2'b11, 1, 1, 1, 0, 16'h0AAA, 16'hFFFF, 16'h0, 16'h0, 4'd0, "R9");
        expect_irq(1, 11, 3, "R9");
        apply(2'b11, 1, 1, 1, 0, 16'h02AA, 16'hFFFF, 16'h0, 16'h0, 4'd0, "R9");
        expect_irq(1, 3, 3, "R9");
        apply(2'b11, 1, 1, 1, 0, 16'h02A2, 16'hFFFF, 16'h0, 16'h0, 4'd0, "R9");
        expect_irq(1, 7, 3, "R9");
        apply(2'b11, 1, 1, 1, 0, 16'h0222, 16'hFFFF, 16'h0, 16'h0, 4'd0, "R9");
        expect_irq(1, 9, 3, "R9");
        apply(2'b11, 1, 1, 1, 0, 16'h0022, 16'hFFFF, 16'h0, 16'h0, 4'd0, "R9");
        expect_irq(1, 1, 3, "R9");
        apply(2'b11, 1, 1, 1, 0, 16'h0020, 16'hFFFF, 16'h0, 16'h0, 4'd0, "R9");
        expect_irq(1, 5, 3, "R9");
        // R9: non-source bits never taken; enable masks pending.
        apply(2'b11, 1, 1, 1, 0, 16'hF555, 16'hFFFF, 16'h0, 16'h0, 4'd0, "R9");
        expect_irq(0, 0, 0, "R9");
        apply(2'b00, 1, 1, 0, 0, 16'h0AAA, 16'h0000, 16'h0, 16'h0, 4'd0, "R9");
        expect_irq(0, 0, 0, "R9");

        // R11: random vectors, judged on every clock against the model.
        for (int n = 0; n < 600; n++) begin
            logic [1:0] p;
            bit hu, hs;
            string tag;
            hu = ($urandom_range(0, 7) != 0);
            hs = ($urandom_range(0, 7) != 0);
            case ($urandom_range(0, 2))
                0: p = 2'b00;
                1: p = 2'b01;
                default: p = 2'b11;
            endcase
            if (!hu || !hs) p = 2'b11;
            tag = (!hu || !hs) ? "R8" : "R11";
            apply(p, hu, hs, 1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
                  16'($urandom), 16'($urandom), 4'($urandom), tag);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule